// File: doc/BRIEF.md
# Dual-Mode Address Translation Unit

This block sits in front of the memory system. It turns a load/store address, formed as base plus displacement, into a physical address. An address space identifier (ASID) is chosen from a 16-entry identifier file in one of two ways:

- **Segment style:** the top nibble of the effective address selects the identifier.
- **Access-register style:** the number of the base register used in the address calculation selects the identifier.

The page number, the identifier and the current context (translation enable, problem state, storage key) are then matched against a fully associative 16-entry translation table. The context match is what lets one table serve both addressing models.

Each valid request produces a registered response one clock later, and the response carries exactly one flag:

- **hit:** the physical address is returned.
- **miss:** software should install a translation.
- **protection fault:** a tag matched except for the storage key.

The unit never walks page tables. Software loads translations through a write port, invalidates single entries and flushes the whole table. It also writes the identifier file through the same port.

A small response state machine has two states:

- `RS_IDLE`: no response is presented.
- `RS_RESP`: a response is presented this cycle.

It has four transitions:

- `RS_IDLE -> RS_RESP` when a request arrives.
- `RS_RESP -> RS_RESP` for back-to-back requests.
- `RS_RESP -> RS_IDLE` when no request follows.
- `RS_IDLE -> RS_IDLE` while the port stays quiet.

Top module: `xlat_unit`

## Requirements
- R1: The effective address is `req_base + req_disp` modulo 2^32. On a hit, `rsp_pa` is `{entry PPN (20 bits), effective address bits 11:0}`, so the 4 KiB page offset passes through untranslated.
- R2: In segment style, the identifier file is indexed by effective address bits 31:28, and no masking is applied.
- R3: In access-register style, the identifier file is indexed by `req_breg`. For example, base register 5 selects entry 5.
- R4: Access-register style is in force when `req_ar_op` is 1 or `cfg_global_ar` is 1. Otherwise segment style applies.
- R5: In access-register style, before lookup, `cfg_amode31`=1 clears bit 31 of the effective address, and `cfg_amode31`=0 clears bits 31:24.
- R6: A hit requires an entry that is valid and matches on page number, ASID, translation-enable flag, problem-state flag and storage key against `ctx_xlate_en`, `ctx_problem` and `ctx_key`. If several entries hit, the lowest-numbered one supplies the PPN.
- R7: A lookup that neither hits nor meets the fault rule of R8 reports a miss.
- R8: If no entry hits, but some valid entry matches on everything except the storage key, a protection fault is reported instead of a miss.
- R9: With `cfg_tag24`=1, the page-number compare uses only effective address bits 23:12. Higher bits are ignored.
- R10: A request accepted at one edge is answered at the next edge with `rsp_valid`=1 and exactly one of hit, miss or fault set. Without a request, all response outputs are 0, and `rsp_pa` is 0 unless the response is a hit.
- R11: Software table writes fill entries in round-robin order starting at entry 0, wrapping from entry 15 to entry 0 and overwriting the oldest entry.
- R12: `sw_inv_we` clears the valid bit of entry `sw_inv_idx`. `sw_flush` clears every valid bit in one cycle, resets the fill order to entry 0, and overrides a write or invalidate in the same cycle.
- R13: After reset, all table entries are invalid, the fill order starts at entry 0 and every identifier file entry is 0.
- R14: A lookup in the same cycle as a table or identifier write sees the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_base | input | 32 | Base register value |
| req_disp | input | 32 | Displacement |
| req_breg | input | 4 | Number of the base register |
| req_ar_op | input | 1 | Per-request access-register style |
| cfg_global_ar | input | 1 | Global access-register style |
| cfg_amode31 | input | 1 | 1: 31-bit mask, 0: 24-bit mask (access-register style) |
| cfg_tag24 | input | 1 | Compare only page bits below the 24-bit boundary |
| ctx_xlate_en | input | 1 | Context translation-enable flag |
| ctx_problem | input | 1 | Context problem/supervisor state |
| ctx_key | input | 4 | Context storage key |
| sw_tlb_we | input | 1 | Write one table entry at the fill pointer |
| sw_tlb_vpn | input | 20 | Entry page number |
| sw_tlb_asid | input | 8 | Entry ASID |
| sw_tlb_ppn | input | 20 | Entry physical page number |
| sw_tlb_xen | input | 1 | Entry translation-enable flag |
| sw_tlb_prob | input | 1 | Entry problem-state flag |
| sw_tlb_key | input | 4 | Entry storage key |
| sw_inv_we | input | 1 | Invalidate one entry |
| sw_inv_idx | input | 4 | Entry to invalidate |
| sw_flush | input | 1 | Invalidate all entries |
| sw_asid_we | input | 1 | Identifier file write strobe |
| sw_asid_idx | input | 4 | Identifier file index |
| sw_asid_val | input | 8 | Identifier value |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | No translation |
| rsp_pfault | output | 1 | Storage-key mismatch |
| rsp_pa | output | 32 | Physical address on a hit, else 0 |

## Verification
Lookups are tried with four kinds of input pattern:

- **Same address under both indexing styles:** pairs of lookups on one address, differing only in style, show whether the identifier comes from the address nibble or from the base register number, and whether the per-request and global selectors both take effect.
- **High address bits set:** these expose the 31-bit and 24-bit masks and the reduced compare, each against an unmasked control case.
- **Context changes on a resident page:** changing only the key, only the problem state or only the enable flag separates protection faults from plain misses.
- **Table management:** fills past sixteen entries, single invalidates, flushes, and writes in the same cycle as lookups show the replacement order and that a lookup sees the table as it was before the write.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int EA_W     = 32;
    localparam int PG_W     = 12;
    localparam int VPN_W    = EA_W - PG_W;
    localparam int PPN_W    = 20;
    localparam int PA_W     = PPN_W + PG_W;
    localparam int ASID_W   = 8;
    localparam int KEY_W    = 4;
    localparam int SEL_W    = 4;
    localparam int LOW24_W  = 24 - PG_W;

    typedef struct packed {
        logic              valid;
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic              xen;
        logic              prob;
        logic [KEY_W-1:0]  key;
        logic [PPN_W-1:0]  ppn;
    } tlb_ent_t;

    typedef enum logic [0:0] {
        RS_IDLE = 1'b0,
        RS_RESP = 1'b1
    } rsp_state_t;
endpackage

// File: rtl/xlat_agen.sv
module xlat_agen
    import xlat_pkg::*;
(
    input  logic [EA_W-1:0]  base,
    input  logic [EA_W-1:0]  disp,
    input  logic [SEL_W-1:0] breg,
    input  logic             ar_op,
    input  logic             global_ar,
    input  logic             amode31,
    output logic [EA_W-1:0]  ea,
    output logic [SEL_W-1:0] sel
);
    localparam logic [EA_W-1:0] MASK31 = {1'b0, {(EA_W-1){1'b1}}};
    localparam logic [EA_W-1:0] MASK24 = {{(EA_W-24){1'b0}}, {24{1'b1}}};

    logic [EA_W-1:0] raw;
    logic            ar_mode;

    always_comb begin
        raw     = base + disp;
        ar_mode = ar_op | global_ar;
        if (ar_mode) begin
            ea  = raw & (amode31 ? MASK31 : MASK24);
            sel = breg;
        end else begin
            ea  = raw;
            sel = raw[EA_W-1 -: SEL_W];
        end
    end
endmodule

// File: rtl/xlat_asid_file.sv
module xlat_asid_file
    import xlat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SEL_W-1:0]  widx,
    input  logic [ASID_W-1:0] wval,
    input  logic [SEL_W-1:0]  ridx,
    output logic [ASID_W-1:0] rval
);
    localparam int DEPTH = 1 << SEL_W;

    logic [ASID_W-1:0] regs [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
        end else if (we) begin
            regs[widx] <= wval;
        end
    end

    assign rval = regs[ridx];
endmodule

// File: rtl/xlat_cam.sv
module xlat_cam
    import xlat_pkg::*;
#(
    parameter int N_ENT = 16,
    localparam int ENT_W = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  tlb_ent_t          wr_ent,
    input  logic              inv_en,
    input  logic [ENT_W-1:0]  inv_idx,
    input  logic              flush,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_xen,
    input  logic              lk_prob,
    input  logic [KEY_W-1:0]  lk_key,
    input  logic              tag24,
    output logic              full_hit,
    output logic              key_fault,
    output logic [PPN_W-1:0]  hit_ppn
);
    localparam logic [ENT_W-1:0] LAST = ENT_W'(N_ENT - 1);
    localparam logic [VPN_W-1:0] MASK_ALL = '1;
    localparam logic [VPN_W-1:0] MASK_LOW = {{(VPN_W-LOW24_W){1'b0}}, {LOW24_W{1'b1}}};

    tlb_ent_t         ents [N_ENT];
    logic [ENT_W-1:0] fill_ptr;
    logic [N_ENT-1:0] base_m, full_m, near_m;
    logic [VPN_W-1:0] vmask;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENT; i++) ents[i] <= '0;
            fill_ptr <= '0;
        end else if (flush) begin
            for (int i = 0; i < N_ENT; i++) ents[i].valid <= 1'b0;
            fill_ptr <= '0;
        end else begin
            if (inv_en) ents[inv_idx].valid <= 1'b0;
            if (wr_en) begin
                ents[fill_ptr] <= wr_ent;
                fill_ptr       <= (fill_ptr == LAST) ? '0 : fill_ptr + 1'b1;
            end
        end
    end

    assign vmask = tag24 ? MASK_LOW : MASK_ALL;

    for (genvar g = 0; g < N_ENT; g++) begin : g_match
        assign base_m[g] = ents[g].valid
                        && (((ents[g].vpn ^ lk_vpn) & vmask) == '0)
                        && (ents[g].asid == lk_asid)
                        && (ents[g].xen  == lk_xen)
                        && (ents[g].prob == lk_prob);
        assign full_m[g] = base_m[g] && (ents[g].key == lk_key);
        assign near_m[g] = base_m[g] && (ents[g].key != lk_key);
    end

    always_comb begin
        hit_ppn = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (full_m[i]) hit_ppn = ents[i].ppn;
        end
    end

    assign full_hit  = |full_m;
    assign key_fault = |near_m;
endmodule

// File: rtl/xlat_unit.sv
module xlat_unit
    import xlat_pkg::*;
#(
    parameter int N_ENT = 16,
    localparam int ENT_W = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [EA_W-1:0]   req_base,
    input  logic [EA_W-1:0]   req_disp,
    input  logic [SEL_W-1:0]  req_breg,
    input  logic              req_ar_op,
    input  logic              cfg_global_ar,
    input  logic              cfg_amode31,
    input  logic              cfg_tag24,
    input  logic              ctx_xlate_en,
    input  logic              ctx_problem,
    input  logic [KEY_W-1:0]  ctx_key,
    input  logic              sw_tlb_we,
    input  logic [VPN_W-1:0]  sw_tlb_vpn,
    input  logic [ASID_W-1:0] sw_tlb_asid,
    input  logic [PPN_W-1:0]  sw_tlb_ppn,
    input  logic              sw_tlb_xen,
    input  logic              sw_tlb_prob,
    input  logic [KEY_W-1:0]  sw_tlb_key,
    input  logic              sw_inv_we,
    input  logic [ENT_W-1:0]  sw_inv_idx,
    input  logic              sw_flush,
    input  logic              sw_asid_we,
    input  logic [SEL_W-1:0]  sw_asid_idx,
    input  logic [ASID_W-1:0] sw_asid_val,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_pfault,
    output logic [PA_W-1:0]   rsp_pa
);
    logic [EA_W-1:0]   ea;
    logic [SEL_W-1:0]  sel;
    logic [ASID_W-1:0] cur_asid;
    logic              full_hit, key_fault;
    logic [PPN_W-1:0]  hit_ppn;
    tlb_ent_t          new_ent;

    rsp_state_t        state, state_nx;
    logic              r_hit, r_fault;
    logic [PA_W-1:0]   r_pa;

    xlat_agen u_agen (
        .base      (req_base),
        .disp      (req_disp),
        .breg      (req_breg),
        .ar_op     (req_ar_op),
        .global_ar (cfg_global_ar),
        .amode31   (cfg_amode31),
        .ea        (ea),
        .sel       (sel)
    );

    xlat_asid_file u_asid (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (sw_asid_we),
        .widx  (sw_asid_idx),
        .wval  (sw_asid_val),
        .ridx  (sel),
        .rval  (cur_asid)
    );

    always_comb begin
        new_ent       = '0;
        new_ent.valid = 1'b1;
        new_ent.vpn   = sw_tlb_vpn;
        new_ent.asid  = sw_tlb_asid;
        new_ent.xen   = sw_tlb_xen;
        new_ent.prob  = sw_tlb_prob;
        new_ent.key   = sw_tlb_key;
        new_ent.ppn   = sw_tlb_ppn;
    end

    xlat_cam #(.N_ENT(N_ENT)) u_cam (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (sw_tlb_we),
        .wr_ent    (new_ent),
        .inv_en    (sw_inv_we),
        .inv_idx   (sw_inv_idx),
        .flush     (sw_flush),
        .lk_vpn    (ea[EA_W-1:PG_W]),
        .lk_asid   (cur_asid),
        .lk_xen    (ctx_xlate_en),
        .lk_prob   (ctx_problem),
        .lk_key    (ctx_key),
        .tag24     (cfg_tag24),
        .full_hit  (full_hit),
        .key_fault (key_fault),
        .hit_ppn   (hit_ppn)
    );

    always_comb begin
        unique case (state)
            RS_IDLE: state_nx = req_valid ? RS_RESP : RS_IDLE;
            RS_RESP: state_nx = req_valid ? RS_RESP : RS_IDLE;
            default: state_nx = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= RS_IDLE;
            r_hit   <= 1'b0;
            r_fault <= 1'b0;
            r_pa    <= '0;
        end else begin
            state <= state_nx;
            if (req_valid) begin
                r_hit   <= full_hit;
                r_fault <= key_fault;
                r_pa    <= {hit_ppn, ea[PG_W-1:0]};
            end
        end
    end

    always_comb begin
        rsp_valid  = 1'b0;
        rsp_hit    = 1'b0;
        rsp_miss   = 1'b0;
        rsp_pfault = 1'b0;
        rsp_pa     = '0;
        unique case (state)
            RS_IDLE: ;
            RS_RESP: begin
                rsp_valid  = 1'b1;
                rsp_hit    = r_hit;
                rsp_pfault = !r_hit && r_fault;
                rsp_miss   = !r_hit && !r_fault;
                rsp_pa     = r_hit ? r_pa : '0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/xlat_unit_chk.sv
module xlat_unit_chk
    import xlat_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [EA_W-1:0] req_base,
    input logic [EA_W-1:0] req_disp,
    input logic            sw_flush,
    input logic            rsp_valid,
    input logic            rsp_hit,
    input logic            rsp_miss,
    input logic            rsp_pfault,
    input logic [PA_W-1:0] rsp_pa
);
    logic [PG_W-1:0] off_sum;
    logic            flush_d;

    assign off_sum = req_base[PG_W-1:0] + req_disp[PG_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) flush_d <= 1'b0;
        else        flush_d <= sw_flush;
    end

    AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $onehot({rsp_hit, rsp_miss, rsp_pfault})); // R10
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && !rsp_miss && !rsp_pfault && rsp_pa == '0)); // R10
    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R10
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R10
    AST_PA_ZERO_NOHIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> rsp_pa == '0); // R10
    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!rsp_hit || rsp_pa[PG_W-1:0] == $past(off_sum))); // R1
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_d && req_valid) |=> rsp_miss); // R12
endmodule

bind xlat_unit xlat_unit_chk u_chk (.*);

// File: tb/xlat_unit_test.sv
module xlat_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 0;
    logic [31:0] req_base = 0, req_disp = 0;
    logic [3:0]  req_breg = 0;
    logic        req_ar_op = 0, cfg_global_ar = 0, cfg_amode31 = 1, cfg_tag24 = 0;
    logic        ctx_xlate_en = 1, ctx_problem = 0;
    logic [3:0]  ctx_key = 3;
    logic        sw_tlb_we = 0;
    logic [19:0] sw_tlb_vpn = 0, sw_tlb_ppn = 0;
    logic [7:0]  sw_tlb_asid = 0;
    logic        sw_tlb_xen = 0, sw_tlb_prob = 0;
    logic [3:0]  sw_tlb_key = 0;
    logic        sw_inv_we = 0;
    logic [3:0]  sw_inv_idx = 0;
    logic        sw_flush = 0;
    logic        sw_asid_we = 0;
    logic [3:0]  sw_asid_idx = 0;
    logic [7:0]  sw_asid_val = 0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_pfault;
    logic [31:0] rsp_pa;

    int total = 0, bad = 0;
    string tag = "R10";

    logic        m_v    [16];
    logic [19:0] m_vpn  [16];
    logic [7:0]  m_asid [16];
    logic        m_xen  [16];
    logic        m_prob [16];
    logic [3:0]  m_key  [16];
    logic [19:0] m_ppn  [16];
    logic [7:0]  m_afile[16];
    int          m_ptr = 0;

    always #2 clk = ~clk;

    xlat_unit uut (.*);

    task automatic check(string t, logic [35:0] act, logic [35:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got v/h/m/p/pa=%h expected %h", t, act, exp);
        end
    endtask

    task automatic step();
        logic [31:0] ea;
        logic [3:0]  idx;
        logic [19:0] vm;
        logic        ar, h, p;
        logic [19:0] ppn;
        logic [35:0] exp;
        ar = req_ar_op | cfg_global_ar;
        ea = req_base + req_disp;
        if (ar) ea = ea & (cfg_amode31 ? 32'h7FFF_FFFF : 32'h00FF_FFFF);
        idx = ar ? req_breg : ea[31:28];
        vm  = cfg_tag24 ? 20'h00FFF : 20'hFFFFF;
        h = 0; p = 0; ppn = 0;
        for (int i = 0; i < 16; i++) begin
            if (m_v[i] && ((m_vpn[i] & vm) == (ea[31:12] & vm)) && m_asid[i] == m_afile[idx]
                && m_xen[i] == ctx_xlate_en && m_prob[i] == ctx_problem) begin
                if (m_key[i] == ctx_key) begin
                    if (!h) ppn = m_ppn[i];
                    h = 1;
                end else p = 1;
            end
        end
        if (!req_valid) exp = '0;
        else if (h)     exp = {1'b1, 1'b1, 1'b0, 1'b0, ppn, ea[11:0]};
        else            exp = {1'b1, 1'b0, !p, p, 32'h0};
        if (sw_flush) begin
            for (int i = 0; i < 16; i++) m_v[i] = 0;
            m_ptr = 0;
        end else begin
            if (sw_inv_we) m_v[sw_inv_idx] = 0;
            if (sw_tlb_we) begin
                m_v[m_ptr] = 1; m_vpn[m_ptr] = sw_tlb_vpn; m_asid[m_ptr] = sw_tlb_asid;
                m_xen[m_ptr] = sw_tlb_xen; m_prob[m_ptr] = sw_tlb_prob;
                m_key[m_ptr] = sw_tlb_key; m_ppn[m_ptr] = sw_tlb_ppn;
                m_ptr = (m_ptr + 1) % 16;
            end
        end
        if (sw_asid_we) m_afile[sw_asid_idx] = sw_asid_val;
        @(posedge clk); #1;
        check(tag, {rsp_valid, rsp_hit, rsp_miss, rsp_pfault, rsp_pa}, exp);
        req_valid = 0; sw_tlb_we = 0; sw_inv_we = 0; sw_flush = 0; sw_asid_we = 0;
    endtask

    task automatic put(logic [19:0] vpn, logic [7:0] asid, logic [19:0] ppn, logic [3:0] key);
        sw_tlb_we = 1; sw_tlb_vpn = vpn; sw_tlb_asid = asid; sw_tlb_ppn = ppn;
        sw_tlb_xen = 1; sw_tlb_prob = 0; sw_tlb_key = key;
        step();
    endtask

    task automatic set_asid(logic [3:0] i, logic [7:0] v);
        sw_asid_we = 1; sw_asid_idx = i; sw_asid_val = v;
        step();
    endtask

    task automatic look(string t, logic [31:0] b, logic [31:0] d, logic [3:0] br, logic ar);
        tag = t; req_valid = 1; req_base = b; req_disp = d; req_breg = br; req_ar_op = ar;
        step();
        tag = "R10";
        step();
    endtask

    initial begin
        #(4 * 200000);
        bad++; total++;
        $display("FAIL watchdog R10: got hang expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin m_v[i] = 0; m_afile[i] = 0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        tag = "R13"; step();                               // R13 reset outputs quiet
        look("R7", 32'h1234_5000, 32'h0, 0, 0);             // R7 empty table misses
        put(20'h12345, 8'h00, 20'hABCDE, 4'h3);
        look("R13", 32'h1234_5000, 32'h123, 0, 0);          // R13 zeroed identifiers
        look("R1", 32'h1234_4F00, 32'h1FF, 0, 0);           // R1 carry into page
        set_asid(4'h1, 8'h11);
        put(20'h10002, 8'h11, 20'h55555, 4'h3);
        look("R2", 32'h1000_0000, 32'h2FFF, 9, 0);          // R2 nibble index
        look("R3", 32'h1000_2000, 32'h0, 1, 1);             // R3 breg 1 selects 0x11
        look("R3", 32'h1000_2000, 32'h0, 2, 1);             // R3 breg 2 misses
        set_asid(4'h5, 8'h55);
        put(20'h00007, 8'h55, 20'h00777, 4'h3);
        look("R4", 32'h0000_7000, 32'h10, 5, 1);            // R4 per-request
        look("R4", 32'h0000_7000, 32'h10, 5, 0);            // R4 segment style misses
        cfg_global_ar = 1;
        look("R4", 32'h0000_7000, 32'h10, 5, 0);            // R4 global bit
        cfg_global_ar = 0;
        look("R5", 32'h8000_7000, 32'h4, 5, 1);             // R5 31-bit mask
        cfg_amode31 = 0;
        look("R5", 32'h7F00_7000, 32'h4, 5, 1);             // R5 24-bit mask
        cfg_amode31 = 1;
        look("R5", 32'h7F00_7000, 32'h4, 5, 1);             // R5 31-bit keeps bits
        look("R2", 32'h8000_7000, 32'h0, 5, 0);             // R2 no mask in segment style
        ctx_key = 4'h4;
        look("R8", 32'h1234_5000, 32'h8, 0, 0);             // R8 key mismatch
        ctx_key = 4'h3; ctx_problem = 1;
        look("R6", 32'h1234_5000, 32'h8, 0, 0);             // R6 state mismatch misses
        ctx_problem = 0; ctx_xlate_en = 0;
        look("R6", 32'h1234_5000, 32'h8, 0, 0);             // R6 enable mismatch misses
        ctx_xlate_en = 1;
        look("R9", 32'h0034_5000, 32'h0, 0, 0);             // R9 full compare misses
        cfg_tag24 = 1;
        look("R9", 32'h0034_5000, 32'h0, 0, 0);             // R9 reduced compare hits
        cfg_tag24 = 0;
        tag = "R14"; req_valid = 1; req_base = 32'h2000_0000; req_disp = 0; req_ar_op = 0;
        sw_tlb_we = 1; sw_tlb_vpn = 20'h20000; sw_tlb_asid = 0; sw_tlb_ppn = 20'h0BEEF;
        sw_tlb_xen = 1; sw_tlb_prob = 0; sw_tlb_key = 3;
        step();                                              // R14 sees old table
        look("R14", 32'h2000_0000, 32'h0, 0, 0);
        for (int i = 0; i < 12; i++) put(20'h40000 + 20'(i), 8'h00, 20'h60000 + 20'(i), 4'h3);
        put(20'h77777, 8'h00, 20'h01234, 4'h3);             // R11 wraps onto entry 0
        look("R11", 32'h1234_5000, 32'h0, 0, 0);            // R11 oldest gone
        look("R11", 32'h7777_7000, 32'h0, 0, 0);
        look("R11", 32'h4000_B000, 32'h0, 0, 0);
        sw_inv_we = 1; sw_inv_idx = 4'd1; tag = "R12"; step();
        look("R12", 32'h1000_2000, 32'h0, 1, 1);            // R12 invalidated entry
        look("R12", 32'h0000_7000, 32'h0, 5, 1);            // R12 neighbour intact
        sw_flush = 1; sw_tlb_we = 1; sw_tlb_vpn = 20'h55555; tag = "R12"; step();
        look("R12", 32'h0000_7000, 32'h0, 5, 1);            // R12 flush empties
        look("R12", 32'h5555_5000, 32'h0, 0, 0);            // R12 write dropped
        put(20'h33333, 8'h00, 20'h03333, 4'h3);
        look("R11", 32'h3333_3000, 32'h0, 0, 0);
        for (int i = 0; i < 15; i++) put(20'h50000 + 20'(i), 8'h00, 20'h0, 4'h3);
        look("R11", 32'h3333_3000, 32'h0, 0, 0);            // R11 entry 0 still held
        put(20'h66666, 8'h00, 20'h06666, 4'h3);
        look("R11", 32'h3333_3000, 32'h0, 0, 0);            // R11 now evicted
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule